// File: doc/BRIEF.md
# Character LCD 4-bit nibble controller

This block drives a character display over a four-bit data path and keeps all of the timing in hardware. After reset it waits for the display to power up, runs the wake-up sequence that moves the display into four-bit mode, and sends a short set of configuration commands. When that is done it offers a valid/ready request port. A host hands over one byte per request, together with a flag that marks the byte as a command or as character data. Two further request flags ask for a screen clear or a cursor-home operation without the host having to know their command codes.

Each byte leaves the block as two nibbles, upper nibble first. Each nibble is latched into the display by a timed enable pulse, with guard intervals before and after the pulse. After every byte the block waits a fixed settle time. Clear and home add a much longer wait. The display's busy flag is therefore never read. All waits are derived from a clock-frequency parameter, so a shorter wait set can be used for simulation.

Top module: `lcd_nibble_ctrl`

## Requirements
- R1: The 7-bit pin vector carries the display data nibble in bits 3..0 (bit 3 is the most significant line), the register-select line in bit 4, the enable line in bit 5 and the read/write line in bit 6. While reset is held, every pin is 0 and ready is 0.
- R2: After reset the enable line stays low for at least 50 long waits. One long wait is 5 ms of clock cycles.
- R3: The wake-up sequence first gives three enable pulses with nibble 0x3 and then one pulse with nibble 0x2. Register select is 0 for all four. At least one long wait passes after each of these pulses before the next pulse.
- R4: Once in four-bit mode, the block sends the commands 0x24, 0x0C and 0x04 in that order, each as a full byte with register select 0.
- R5: Every byte is sent as exactly two enable pulses, the upper nibble first and the lower nibble second. Register select is 1 for a data request and 0 for a command request.
- R6: After the lower-nibble pulse of a byte, at least one short wait (50 µs of clock cycles) passes before the next enable pulse rises or ready returns high.
- R7: A clear request sends command 0x01 and a home request sends command 0x02. Register select is 0 for both.
- R8: When several request flags are set in the same accepted request, clear wins over home, and home wins over the byte input.
- R9: The read/write line is 0 in every cycle.
- R10: Each enable pulse is high for at least 16 cycles. The data nibble and register select do not change for at least 4 cycles before enable rises, while it is high, or for at least 4 cycles after it falls.
- R11: Ready is low throughout initialisation and while any pulse or wait is in progress. A request is taken only in a cycle where valid and ready are both high. Each taken request produces exactly one byte on the pins.
- R12: The long wait is the clock frequency divided by 200 cycles and the short wait is the clock frequency divided by 20000 cycles. After a clear or a home, both waits pass, one after the other, before ready returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host offers a request |
| req_byte | input | 8 | Byte to send when neither clear nor home is set |
| req_is_data | input | 1 | 1 sends req_byte as character data, 0 sends it as a command |
| req_clear | input | 1 | Requests a screen clear |
| req_home | input | 1 | Requests a cursor-home operation |
| req_ready | output | 1 | Block is idle and will take a request in this cycle |
| lcd_pins | output | 7 | Display lines: nibble in 3..0, register select 4, enable 5, read/write 6 |

## Verification
Two overlaps in the same cycle are provoked. First, a request is held valid through a busy period, so that it is taken in the very cycle ready returns high; the check is that it appears on the pins exactly once. Second, clear, home and data flags are raised together in one request; the check is that the winner given by R8 appears on the pins. A behavioural model in the bench keeps a queue of expected nibbles, each with its register-select value and a minimum quiet time. The monitor decodes each enable pulse and judges its width, its setup and hold margins, and the gap before the next activity or before ready rises.

// File: rtl/lcd_nibble_pkg.sv
package lcd_nibble_pkg;

  typedef enum logic [2:0] {
    SQ_PWR,
    SQ_HI,
    SQ_LO,
    SQ_WAIT,
    SQ_IDLE
  } seq_state_e;

  typedef enum logic [1:0] {
    SB_IDLE,
    SB_SETUP,
    SB_PULSE,
    SB_HOLD
  } strobe_state_e;

  typedef struct packed {
    logic [7:0] value;
    logic       nib_only;
    logic       long_wait;
  } init_step_t;

  localparam int         INIT_STEPS = 7;
  localparam logic [7:0] CMD_CLEAR  = 8'h01;
  localparam logic [7:0] CMD_HOME   = 8'h02;

  // Wake-up nibbles live in the upper half of value; configuration bytes follow.
  function automatic init_step_t init_step(input logic [2:0] idx);
    init_step_t s;
    case (idx)
      3'd0, 3'd1, 3'd2: s = '{value: 8'h30, nib_only: 1'b1, long_wait: 1'b1};
      3'd3:             s = '{value: 8'h20, nib_only: 1'b1, long_wait: 1'b1};
      3'd4:             s = '{value: 8'h24, nib_only: 1'b0, long_wait: 1'b0};
      3'd5:             s = '{value: 8'h0C, nib_only: 1'b0, long_wait: 1'b0};
      default:          s = '{value: 8'h04, nib_only: 1'b0, long_wait: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
  parameter int          W       = 24,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_VAL;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R12: a zero wait would skip the settle time entirely
  a_r12_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/lcd_nibble_strobe.sv
module lcd_nibble_strobe
  import lcd_nibble_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int EN_CYC    = 16,
  parameter int HOLD_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] nib_in,
  input  logic       rs_in,
  output logic [3:0] nib,
  output logic       rs,
  output logic       en,
  output logic       done
);

  localparam int MAX_AB = (SETUP_CYC > EN_CYC) ? SETUP_CYC : EN_CYC;
  localparam int MAXC   = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  strobe_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    nib_q, nib_d;
  logic          rs_q, rs_d, en_q, en_d;

  assign done = (state_q == SB_HOLD) && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    nib_d   = nib_q;
    rs_d    = rs_q;
    en_d    = en_q;
    case (state_q)
      SB_SETUP: begin
        if (cnt_q == '0) begin
          state_d = SB_PULSE;
          cnt_d   = CW'(EN_CYC - 1);
          en_d    = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      SB_PULSE: begin
        if (cnt_q == '0) begin
          state_d = SB_HOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
          en_d    = 1'b0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      SB_HOLD: begin
        if (cnt_q == '0) begin
          state_d = SB_IDLE;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: ;
    endcase
    if (start && (state_q == SB_IDLE || done)) begin
      state_d = SB_SETUP;
      cnt_d   = CW'(SETUP_CYC - 1);
      nib_d   = nib_in;
      rs_d    = rs_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SB_IDLE;
      cnt_q   <= '0;
      nib_q   <= '0;
      rs_q    <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nib_q   <= nib_d;
      rs_q    <= rs_d;
      en_q    <= en_d;
    end
  end

  assign nib = nib_q;
  assign rs  = rs_q;
  assign en  = en_q;

  // R10: lines frozen on the edge enable rises and for as long as it stays high
  a_r10_lines_frozen_under_en: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> ($stable(nib_q) && $stable(rs_q)));

  // R10: a new nibble is never taken while the previous one is mid-pulse
  a_r10_no_restart_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SB_PULSE) |=> (nib_q == $past(nib_q)));

endmodule

// File: rtl/lcd_nibble_ctrl.sv
module lcd_nibble_ctrl
  import lcd_nibble_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int POWERUP_REPS = 50,
  parameter int SETUP_CYC    = 4,
  parameter int EN_CYC       = 16,
  parameter int HOLD_CYC     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_byte,
  input  logic       req_is_data,
  input  logic       req_clear,
  input  logic       req_home,
  output logic       req_ready,
  output logic [6:0] lcd_pins
);

  localparam int LONG_CYC = CLK_HZ / 200;
  localparam int BYTE_CYC = CLK_HZ / 20000;
  localparam int SLOW_CYC = BYTE_CYC + LONG_CYC;
  localparam int PWR_CYC  = POWERUP_REPS * LONG_CYC;
  localparam int TW       = $clog2(PWR_CYC + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  seq_state_e    state_q, state_d;
  logic [2:0]    idx_q, idx_d;
  logic          init_q, init_d;
  logic [7:0]    byte_q, byte_d;
  logic          rs_q, rs_d;
  logic          single_q, single_d;
  logic [TW-1:0] wait_q, wait_d;

  logic          go, st_rs, st_done, tmr_load, tmr_expired;
  logic [3:0]    st_nib;
  logic [3:0]    nib;
  logic          rs, en;
  init_step_t    step;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    init_d   = init_q;
    byte_d   = byte_q;
    rs_d     = rs_q;
    single_d = single_q;
    wait_d   = wait_q;
    go       = 1'b0;
    st_nib   = byte_q[7:4];
    st_rs    = rs_q;
    tmr_load = 1'b0;
    step     = init_step((state_q == SQ_PWR) ? 3'd0 : idx_q + 3'd1);

    case (state_q)
      SQ_PWR: begin
        if (tmr_expired) begin
          byte_d   = step.value;
          rs_d     = 1'b0;
          single_d = step.nib_only;
          wait_d   = step.long_wait ? TW'(LONG_CYC) : TW'(BYTE_CYC);
          go       = 1'b1;
          st_nib   = step.value[7:4];
          st_rs    = 1'b0;
          state_d  = SQ_HI;
        end
      end
      SQ_HI: begin
        if (st_done) begin
          if (single_q) begin
            tmr_load = 1'b1;
            state_d  = SQ_WAIT;
          end else begin
            go      = 1'b1;
            st_nib  = byte_q[3:0];
            state_d = SQ_LO;
          end
        end
      end
      SQ_LO: begin
        if (st_done) begin
          tmr_load = 1'b1;
          state_d  = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (tmr_expired) begin
          if (init_q && idx_q != 3'(INIT_STEPS - 1)) begin
            idx_d    = idx_q + 3'd1;
            byte_d   = step.value;
            rs_d     = 1'b0;
            single_d = step.nib_only;
            wait_d   = step.long_wait ? TW'(LONG_CYC) : TW'(BYTE_CYC);
            go       = 1'b1;
            st_nib   = step.value[7:4];
            st_rs    = 1'b0;
            state_d  = SQ_HI;
          end else begin
            init_d  = 1'b0;
            state_d = SQ_IDLE;
          end
        end
      end
      SQ_IDLE: begin
        if (req_valid) begin
          single_d = 1'b0;
          if (req_clear) begin
            byte_d = CMD_CLEAR;
            rs_d   = 1'b0;
            wait_d = TW'(SLOW_CYC);
          end else if (req_home) begin
            byte_d = CMD_HOME;
            rs_d   = 1'b0;
            wait_d = TW'(SLOW_CYC);
          end else begin
            byte_d = req_byte;
            rs_d   = req_is_data;
            wait_d = TW'(BYTE_CYC);
          end
          go      = 1'b1;
          st_nib  = byte_d[7:4];
          st_rs   = rs_d;
          state_d = SQ_HI;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q  <= SQ_PWR;
      idx_q    <= 3'd0;
      init_q   <= 1'b1;
      byte_q   <= 8'h00;
      rs_q     <= 1'b0;
      single_q <= 1'b0;
      wait_q   <= '0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      init_q   <= init_d;
      byte_q   <= byte_d;
      rs_q     <= rs_d;
      single_q <= single_d;
      wait_q   <= wait_d;
    end
  end

  lcd_wait_timer #(
    .W       (TW),
    .RST_VAL (TW'(PWR_CYC))
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (tmr_load),
    .load_val (wait_q),
    .expired  (tmr_expired)
  );

  lcd_nibble_strobe #(
    .SETUP_CYC (SETUP_CYC),
    .EN_CYC    (EN_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_i),
    .start  (go),
    .nib_in (st_nib),
    .rs_in  (st_rs),
    .nib    (nib),
    .rs     (rs),
    .en     (en),
    .done   (st_done)
  );

  assign req_ready = (state_q == SQ_IDLE);
  assign lcd_pins  = {1'b0, en, rs, nib};

  // R11: an idle block never has an enable pulse in flight
  a_r11_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_i)
    req_ready |-> !en);

  // R11: a taken request makes the block busy on the next cycle
  a_r11_accept_then_busy: assert property (@(posedge clk) disable iff (!rst_i)
    (req_valid && req_ready) |=> !req_ready);

  // R2: no strobe while the power-up wait runs
  a_r2_dark_powerup: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == SQ_PWR) |-> !en);

  // R4: every pulse of the start-up sequence is a command
  a_r4_init_rs_low: assert property (@(posedge clk) disable iff (!rst_i)
    (init_q && en) |-> !rs);

endmodule

// File: tb/lcd_nibble_ctrl_tb.sv
module lcd_nibble_ctrl_tb;

  localparam int CLK_HZ   = 200_000;
  localparam int LONG_W   = CLK_HZ / 200;
  localparam int SHORT_W  = CLK_HZ / 20000;
  localparam int PWR_W    = 50 * LONG_W;
  localparam int SETUP_W  = 4;
  localparam int PULSE_W  = 16;
  localparam int HOLD_W   = 4;
  localparam int WATCHDOG = 150_000;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_byte;
  logic       req_is_data;
  logic       req_clear;
  logic       req_home;
  logic       req_ready;
  logic [6:0] lcd_pins;

  int n_cmp;
  int n_bad;
  bit summary_done;

  // expected nibble stream
  logic [3:0] q_nib[$];
  logic       q_rs[$];
  int         q_gap[$];
  string      q_tag[$];
  string      q_gtag[$];

  lcd_nibble_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_byte    (req_byte),
    .req_is_data (req_is_data),
    .req_clear   (req_clear),
    .req_home    (req_home),
    .req_ready   (req_ready),
    .lcd_pins    (lcd_pins)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic push_nib(input logic [3:0] n, input logic r, input int gap,
                          input string tag, input string gtag);
    q_nib.push_back(n);
    q_rs.push_back(r);
    q_gap.push_back(gap);
    q_tag.push_back(tag);
    q_gtag.push_back(gtag);
  endtask

  task automatic push_byte(input logic [7:0] b, input logic r, input int gap,
                           input string tag, input string gtag);
    push_nib(b[7:4], r, 0, tag, gtag);
    push_nib(b[3:0], r, gap, tag, gtag);
  endtask

  // held=1: valid raised at once and kept up through the busy period
  task automatic send(input logic [7:0] b, input bit d, input bit c, input bit h,
                      input bit held, input string tag);
    if (!held) begin
      @(negedge clk);
      while (!req_ready) @(negedge clk);
    end
    req_valid   = 1'b1;
    req_byte    = b;
    req_is_data = d;
    req_clear   = c;
    req_home    = h;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_clear = 1'b0;
    req_home  = 1'b0;
    if (c)      push_byte(8'h01, 1'b0, SHORT_W + LONG_W, tag, "R12");
    else if (h) push_byte(8'h02, 1'b0, SHORT_W + LONG_W, tag, "R12");
    else        push_byte(b, d, SHORT_W, tag, "R6");
  endtask

  // per-cycle monitor
  logic       en_prev, rdy_prev;
  logic [4:0] dat_prev;
  int         since_fall, since_data, en_cnt, gap_req;
  string      gap_tag;

  always @(negedge clk) begin
    if (!rst_n) begin
      en_prev    = 1'b0;
      rdy_prev   = 1'b0;
      dat_prev   = 5'd0;
      since_fall = 0;
      since_data = 0;
      en_cnt     = 0;
      gap_req    = PWR_W;
      gap_tag    = "R2";
    end else begin
      logic       en;
      logic [4:0] dat;
      en  = lcd_pins[5];
      dat = lcd_pins[4:0];
      since_fall++;
      since_data++;
      chk(lcd_pins[6] == 1'b0, "R9", "read/write line", lcd_pins[6], 0);
      chk(!(req_ready && en), "R11", "ready while enable high", req_ready, 0);
      if (dat != dat_prev) begin
        chk(!en, "R10", "lines moved under enable", en, 0);
        chk(since_fall >= HOLD_W, "R10", "hold after enable fall", since_fall, HOLD_W);
        since_data = 0;
      end
      if (en && !en_prev) begin
        chk(since_data >= SETUP_W, "R10", "setup before enable rise", since_data, SETUP_W);
        chk(since_fall >= gap_req, gap_tag, "quiet time before pulse", since_fall, gap_req);
        en_cnt = 0;
      end
      if (en) en_cnt++;
      if (!en && en_prev) begin
        chk(en_cnt >= PULSE_W, "R10", "enable width", en_cnt, PULSE_W);
        if (q_nib.size() == 0) begin
          chk(1'b0, "R11", "unexpected enable pulse", dat[3:0], -1);
          gap_req = 0;
          gap_tag = "R11";
        end else begin
          logic [3:0] en_nib;
          logic       en_rs;
          string      tg;
          en_nib = q_nib.pop_front();
          en_rs  = q_rs.pop_front();
          tg     = q_tag.pop_front();
          gap_req = q_gap.pop_front();
          gap_tag = q_gtag.pop_front();
          chk(dat[3:0] == en_nib, tg, "nibble", dat[3:0], en_nib);
          chk(dat[4] == en_rs, tg, "register select", dat[4], en_rs);
        end
        since_fall = 0;
      end
      if (req_ready && !rdy_prev) begin
        chk(since_fall >= gap_req, gap_tag, "quiet time before ready", since_fall, gap_req);
        chk(q_nib.size() == 0, "R11", "ready with nibbles pending", q_nib.size(), 0);
      end
      en_prev  = en;
      dat_prev = dat;
      rdy_prev = req_ready;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R11", "watchdog expired", WATCHDOG, 0);
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0;
    n_bad = 0;
    summary_done = 0;
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_byte    = 8'h00;
    req_is_data = 1'b0;
    req_clear   = 1'b0;
    req_home    = 1'b0;

    // R3: wake-up nibbles, each followed by a long wait
    for (int i = 0; i < 3; i++) push_nib(4'h3, 1'b0, LONG_W, "R3", "R3");
    push_nib(4'h2, 1'b0, LONG_W, "R3", "R3");
    // R4: configuration commands
    push_byte(8'h24, 1'b0, SHORT_W, "R4", "R6");
    push_byte(8'h0C, 1'b0, SHORT_W, "R4", "R6");
    push_byte(8'h04, 1'b0, SHORT_W, "R4", "R6");

    repeat (5) @(negedge clk);
    chk(lcd_pins == 7'd0, "R1", "pins in reset", lcd_pins, 0);
    chk(req_ready == 1'b0, "R1", "ready in reset", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R11", "ready right after reset", req_ready, 0);

    send(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, "R1");   // data byte, layout
    send(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, "R5");   // command byte
    send(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R7");   // clear
    send(8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, "R7");   // home
    send(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, "R8");   // all flags: clear wins
    send(8'h99, 1'b1, 1'b0, 1'b1, 1'b0, "R8");   // home beats byte
    send(8'h42, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    send(8'h7E, 1'b1, 1'b0, 1'b0, 1'b1, "R11");  // held valid through busy
    send(8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");

    @(negedge clk);
    while (!(req_ready && q_nib.size() == 0)) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(q_nib.size() == 0, "R11", "nibbles left over", q_nib.size(), 0);
    chk(lcd_pins[5] == 1'b0, "R11", "enable idle at end", lcd_pins[5], 0);
    summary();
    $finish;
  end

endmodule